// File: doc/BRIEF.md
# Branch History Checkpoint Predictor

This block manages global branch history for a gshare-style direction predictor. Two history registers are kept. The plain history takes every resolved outcome. The modified history also takes every outcome, but it can be checkpointed onto a small stack when a hint marks entry to a loop or subroutine. A matching exit hint copies the checkpoint back, so branches inside the region no longer show up in it. Each history has its own table of 2-bit direction counters, indexed by the low PC bits XORed with that history. A table of 2-bit chooser counters, indexed by PC, decides per branch which of the two sub-predictors supplies the prediction.

The block serves one branch at a time. A branch request in `ST_IDLE` captures the PC and a snapshot of both histories, then moves to `ST_LOOKUP`. `ST_LOOKUP` reads all three tables and registers the prediction, then moves to `ST_RESOLVE`. The block waits in `ST_RESOLVE`, showing the prediction, until the outcome arrives. It then moves to `ST_TRAIN`, where it updates the counters from the snapshot, shifts both histories, and returns to `ST_IDLE`. The named transitions are IDLE→LOOKUP (request), LOOKUP→RESOLVE (always), RESOLVE→RESOLVE (no outcome), RESOLVE→TRAIN (outcome) and TRAIN→IDLE (always). Hints act only in `ST_IDLE`.

Top module: `hist_ckpt_pred`

## Requirements
- R1: After reset, `ready` is 1, `pred_valid` is 0, and both `hist_plain` and `hist_mod` are zero.
- R2: A `br_req` seen while `ready` is 1 drops `ready` on the next cycle and raises `pred_valid` one cycle after that.
- R3: `pred_valid` stays at 1 until a cycle with `res_valid` at 1. `ready` and `pred_valid` are never 1 together. `ready` returns two cycles after the `res_valid` cycle.
- R4: After training, each history register is its value before training shifted left by one, with the outcome (1 = taken) in bit 0.
- R5: Each direction table is indexed by `pc[IDX_W-1:0] XOR history[IDX_W-1:0]`, using that table's own history snapshot. A sub-predictor predicts taken when bit 1 of its counter is 1. All direction counters reset to 01.
- R6: The chooser counter at `pc[CH_W-1:0]` selects the modified sub-predictor when its bit 1 is 1 (`pred_use_mod` = 1). `pred_taken` and `pred_hist` then come from the selected sub-predictor and its snapshot. Chooser counters reset to 01.
- R7: A chooser counter changes only when the two sub-predictions differ. It then saturates up by one if the modified one was correct, and down by one if the plain one was correct.
- R8: Every resolution trains both direction counters at their snapshot indices: up by one saturating at 3 when taken, down by one saturating at 0 when not taken.
- R9: An accepted `hint_enter` pushes the current modified history and leaves it unchanged. An accepted `hint_exit` pops the newest entry into the modified history. Neither hint changes `hist_plain`.
- R10: An accepted `hint_exit` with an empty stack leaves `hist_mod` unchanged.
- R11: A push onto a full stack (STACK_DEPTH entries) discards the oldest entry. Later pops return the newest STACK_DEPTH entries, newest first.
- R12: Hints are accepted only when `ready` is 1 and `br_req` is 0, and otherwise have no effect. When both hints arrive together, only `hint_enter` acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_req | input | 1 | Branch prediction request |
| br_pc | input | PC_W | Branch PC |
| hint_enter | input | 1 | Region entry hint pulse |
| hint_exit | input | 1 | Region exit hint pulse |
| res_valid | input | 1 | Outcome valid |
| res_taken | input | 1 | Outcome, 1 = taken |
| ready | output | 1 | Block is idle and accepts a request or hint |
| pred_valid | output | 1 | Prediction outputs are valid |
| pred_taken | output | 1 | Predicted direction |
| pred_use_mod | output | 1 | Prediction came from the modified history |
| pred_hist | output | HIST_W | History snapshot that produced the prediction |
| hist_plain | output | HIST_W | Current plain history |
| hist_mod | output | HIST_W | Current modified history |

## Verification
The assertions assume the block is driven as a well-behaved front end would drive it. A request is raised only while `ready` is high. `res_valid` is pulsed once per prediction, while `pred_valid` is high. Hint pulses are single cycles.

The stimulus keeps to these rules. Its tasks wait for `ready` before issuing a request or an accepted hint, and they pulse `res_valid` for exactly one cycle once `pred_valid` is seen. The only time hints are raised outside the idle state is on purpose, during the lookup and resolve phases or together with a request, to show that they are ignored.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_RESOLVE,
        ST_TRAIN
    } hcp_state_e;

    // 2-bit saturating counter step
    function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
        if (up) return (cur == 2'b11) ? 2'b11 : cur + 2'b01;
        else    return (cur == 2'b00) ? 2'b00 : cur - 2'b01;
    endfunction

endpackage

// File: rtl/hcp_ctr_table.sv
module hcp_ctr_table
    import hcp_pkg::*;
#(
    parameter int         IDX_W   = 8,
    parameter logic [1:0] RST_VAL = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] ctr_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctr_q[g] <= RST_VAL;
            else if (upd_en && (upd_idx == IDX_W'(g)))
                ctr_q[g] <= sat_step(ctr_q[g], upd_up);
        end
    end

    assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/hcp_hist_stack.sv
module hcp_hist_stack #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     ent_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    // entry 0 is newest; a push shifts toward DEPTH-1, dropping the oldest
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;
        if (g == 0) begin : g_head
            assign from_above = push_data;
        end else begin : g_body
            assign from_above = ent_q[g-1];
        end
        if (g == DEPTH - 1) begin : g_tail
            assign from_below = '0;
        end else begin : g_mid
            assign from_below = ent_q[g+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (push)
                ent_q[g] <= from_above;
            else if (pop)
                ent_q[g] <= from_below;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push) begin
            if (cnt_q != CNT_W'(DEPTH))
                cnt_q <= cnt_q + 1'b1;
        end else if (pop && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign top_data = ent_q[0];
    assign empty    = (cnt_q == '0);

endmodule

// File: rtl/hist_ckpt_pred.sv
module hist_ckpt_pred
    import hcp_pkg::*;
#(
    parameter int HIST_W      = 12,
    parameter int IDX_W       = 8,
    parameter int CH_W        = 6,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_req,
    input  logic [PC_W-1:0]   br_pc,
    input  logic              hint_enter,
    input  logic              hint_exit,
    input  logic              res_valid,
    input  logic              res_taken,
    output logic              ready,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic              pred_use_mod,
    output logic [HIST_W-1:0] pred_hist,
    output logic [HIST_W-1:0] hist_plain,
    output logic [HIST_W-1:0] hist_mod
);
    hcp_state_e state_q, state_d;

    logic [PC_W-1:0]   pc_q;
    logic [HIST_W-1:0] snap_plain_q, snap_mod_q;
    logic [HIST_W-1:0] plain_q, mod_q;
    logic              outcome_q;
    logic              pt_q, mt_q, use_mod_q, taken_q;
    logic [HIST_W-1:0] hist_sel_q;

    logic [IDX_W-1:0] idx_plain, idx_mod;
    logic [CH_W-1:0]  idx_ch;
    logic [1:0]       ctr_plain, ctr_mod, ctr_ch;
    logic             hint_ok, do_push, do_pop;
    logic             stk_empty;
    logic [HIST_W-1:0] stk_top;
    logic             training;

    // gshare indices come from the snapshot captured at request time
    assign idx_plain = pc_q[IDX_W-1:0] ^ snap_plain_q[IDX_W-1:0];
    assign idx_mod   = pc_q[IDX_W-1:0] ^ snap_mod_q[IDX_W-1:0];
    assign idx_ch    = pc_q[CH_W-1:0];
    assign training  = (state_q == ST_TRAIN);

    // hints only act when idle and no request competes; entry wins over exit
    assign hint_ok = (state_q == ST_IDLE) && !br_req;
    assign do_push = hint_ok && hint_enter;
    assign do_pop  = hint_ok && hint_exit && !hint_enter && !stk_empty;

    hcp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(2'b01)) u_pht_plain (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx_plain), .rd_ctr(ctr_plain),
        .upd_en(training), .upd_idx(idx_plain), .upd_up(outcome_q)
    );

    hcp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(2'b01)) u_pht_mod (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx_mod), .rd_ctr(ctr_mod),
        .upd_en(training), .upd_idx(idx_mod), .upd_up(outcome_q)
    );

    // chooser trains only on disagreement, toward the correct side
    hcp_ctr_table #(.IDX_W(CH_W), .RST_VAL(2'b01)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx_ch), .rd_ctr(ctr_ch),
        .upd_en(training && (pt_q != mt_q)), .upd_idx(idx_ch),
        .upd_up(mt_q == outcome_q)
    );

    hcp_hist_stack #(.W(HIST_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(do_push), .pop(do_pop),
        .push_data(mod_q), .top_data(stk_top), .empty(stk_empty)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (br_req) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = ST_RESOLVE;
            ST_RESOLVE: if (res_valid) state_d = ST_TRAIN;
            ST_TRAIN:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and outcome latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q         <= '0;
            snap_plain_q <= '0;
            snap_mod_q   <= '0;
            outcome_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && br_req) begin
                pc_q         <= br_pc;
                snap_plain_q <= plain_q;
                snap_mod_q   <= mod_q;
            end
            if (state_q == ST_RESOLVE && res_valid)
                outcome_q <= res_taken;
        end
    end

    // history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plain_q <= '0;
            mod_q   <= '0;
        end else if (training) begin
            plain_q <= {plain_q[HIST_W-2:0], outcome_q};
            mod_q   <= {mod_q[HIST_W-2:0], outcome_q};
        end else if (do_pop) begin
            mod_q   <= stk_top;
        end
    end

    // output registers, loaded in the lookup state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q       <= 1'b0;
            mt_q       <= 1'b0;
            use_mod_q  <= 1'b0;
            taken_q    <= 1'b0;
            hist_sel_q <= '0;
        end else if (state_q == ST_LOOKUP) begin
            pt_q       <= ctr_plain[1];
            mt_q       <= ctr_mod[1];
            use_mod_q  <= ctr_ch[1];
            taken_q    <= ctr_ch[1] ? ctr_mod[1] : ctr_plain[1];
            hist_sel_q <= ctr_ch[1] ? snap_mod_q : snap_plain_q;
        end
    end

    assign ready        = (state_q == ST_IDLE);
    assign pred_valid   = (state_q == ST_RESOLVE);
    assign pred_taken   = taken_q;
    assign pred_use_mod = use_mod_q;
    assign pred_hist    = hist_sel_q;
    assign hist_plain   = plain_q;
    assign hist_mod     = mod_q;

endmodule

// File: rtl/hist_ckpt_pred_chk.sv
module hist_ckpt_pred_chk #(
    parameter int HIST_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              br_req,
    input logic              pred_valid,
    input logic              res_valid,
    input logic              res_taken,
    input logic [HIST_W-1:0] hist_plain,
    input logic [HIST_W-1:0] hist_mod
);
    // R2
    lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && br_req) |=> (!ready ##1 pred_valid));

    // R3
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !res_valid) |=> pred_valid);

    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && pred_valid));

    // R3
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && res_valid) |=> (!ready ##1 ready));

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && res_valid) |=> ##1
            ((hist_plain[0] == $past(res_taken, 2)) && (hist_mod[0] == $past(res_taken, 2))));

    // R9
    plain_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !br_req) |=> $stable(hist_plain));

    // R12
    busy_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |=> $stable(hist_mod));

    // R12
    req_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && br_req) |=> $stable(hist_mod));

endmodule

bind hist_ckpt_pred hist_ckpt_pred_chk #(.HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .br_req(br_req),
    .pred_valid(pred_valid), .res_valid(res_valid), .res_taken(res_taken),
    .hist_plain(hist_plain), .hist_mod(hist_mod)
);

// File: tb/hist_ckpt_pred_bench.sv
module hist_ckpt_pred_bench;
    localparam int HIST_W = 12;
    localparam int IDX_W  = 8;
    localparam int CH_W   = 6;
    localparam int PC_W   = 16;
    localparam int DEPTH  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_req = 1'b0;
    logic [PC_W-1:0] br_pc = '0;
    logic hint_enter = 1'b0, hint_exit = 1'b0;
    logic res_valid = 1'b0, res_taken = 1'b0;
    logic ready, pred_valid, pred_taken, pred_use_mod;
    logic [HIST_W-1:0] pred_hist, hist_plain, hist_mod;

    always #4 clk = ~clk;

    hist_ckpt_pred #(.HIST_W(HIST_W), .IDX_W(IDX_W), .CH_W(CH_W), .PC_W(PC_W),
                     .STACK_DEPTH(DEPTH)) u_hist_ckpt_pred (
        .clk(clk), .rst_n(rst_n), .br_req(br_req), .br_pc(br_pc),
        .hint_enter(hint_enter), .hint_exit(hint_exit),
        .res_valid(res_valid), .res_taken(res_taken),
        .ready(ready), .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_use_mod(pred_use_mod), .pred_hist(pred_hist),
        .hist_plain(hist_plain), .hist_mod(hist_mod)
    );

    // reference model
    int m_pp [1 << IDX_W];
    int m_pm [1 << IDX_W];
    int m_ch [1 << CH_W];
    logic [HIST_W-1:0] m_plain, m_mod;
    logic [HIST_W-1:0] m_stk [DEPTH];
    int m_cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sat(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 50) begin @(negedge clk); guard++; end
    endtask

    task automatic do_branch(input logic [PC_W-1:0] pc, input bit taken,
                             input bit busy_hint, input bit req_hint);
        int ip, im, ic, guard;
        bit pt, mt, um;
        wait_ready();
        br_req = 1'b1; br_pc = pc;
        hint_enter = req_hint; hint_exit = req_hint;
        @(negedge clk);
        br_req = 1'b0;
        hint_enter = busy_hint; hint_exit = busy_hint;
        ip = int'((pc ^ PC_W'(m_plain)) & 16'h00FF);
        im = int'((pc ^ PC_W'(m_mod)) & 16'h00FF);
        ic = int'(pc & 16'h003F);
        pt = (m_pp[ip] >= 2); mt = (m_pm[im] >= 2); um = (m_ch[ic] >= 2);
        guard = 0;
        while (!pred_valid && guard < 50) begin @(negedge clk); guard++; end
        // R5 R6 R7 R8
        chk(pred_use_mod == um, "R6,R7 chooser select", pred_use_mod, um);
        chk(pred_taken == (um ? mt : pt), "R5,R8 predicted direction", pred_taken, um ? mt : pt);
        chk(pred_hist == (um ? m_mod : m_plain), "R6 chosen history", pred_hist, um ? m_mod : m_plain);
        @(negedge clk); // linger one cycle in resolve: R3 hold
        chk(pred_valid == 1'b1 && ready == 1'b0, "R3 prediction held", pred_valid, 1);
        res_valid = 1'b1; res_taken = taken;
        @(negedge clk);
        res_valid = 1'b0; hint_enter = 1'b0; hint_exit = 1'b0;
        chk(ready == 1'b0, "R3 busy during training", ready, 0);
        @(negedge clk);
        m_pp[ip] = sat(m_pp[ip], taken);
        m_pm[im] = sat(m_pm[im], taken);
        if (pt != mt) m_ch[ic] = sat(m_ch[ic], mt == taken);
        m_plain = {m_plain[HIST_W-2:0], taken};
        m_mod   = {m_mod[HIST_W-2:0], taken};
        chk(ready == 1'b1, "R3 ready returns", ready, 1);
        // R4 R12
        chk(hist_plain == m_plain, "R4 plain shift", hist_plain, m_plain);
        chk(hist_mod == m_mod, "R4,R12 modified shift", hist_mod, m_mod);
    endtask

    task automatic do_hint(input bit en, input bit ex, input string req);
        wait_ready();
        hint_enter = en; hint_exit = ex;
        @(negedge clk);
        hint_enter = 1'b0; hint_exit = 1'b0;
        if (en) begin
            for (int i = DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = m_mod;
            if (m_cnt < DEPTH) m_cnt++;
        end else if (ex && m_cnt > 0) begin
            m_mod = m_stk[0];
            for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
            m_stk[DEPTH-1] = '0;
            m_cnt--;
        end
        chk(hist_mod == m_mod, req, hist_mod, m_mod);
        chk(hist_plain == m_plain, "R9 plain untouched by hint", hist_plain, m_plain);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
        end
    end

    initial begin
        logic [PC_W-1:0] pcs [6];
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << IDX_W); i++) begin m_pp[i] = 1; m_pm[i] = 1; end
        for (int i = 0; i < (1 << CH_W); i++) m_ch[i] = 1;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
        m_plain = '0; m_mod = '0; m_cnt = 0;
        for (int i = 0; i < 6; i++) pcs[i] = PC_W'(i * 37 + 5);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        chk(pred_valid == 1'b0, "R1 no prediction after reset", pred_valid, 0);
        chk(hist_plain == '0 && hist_mod == '0, "R1 histories cleared", {hist_plain, hist_mod}, 0);

        // R10 pop from empty stack
        do_hint(1'b0, 1'b1, "R10 pop when empty");

        // R5 first prediction not taken from weak counters
        do_branch(16'h0011, 1'b1, 1'b0, 1'b0);
        do_branch(16'h0011, 1'b1, 1'b0, 1'b0);

        // R9 R11 fill past capacity then drain
        for (int k = 0; k < DEPTH + 1; k++) begin
            do_branch(PC_W'(k + 3), k[0] ^ k[1], 1'b0, 1'b0);
            do_hint(1'b1, 1'b0, "R9 push keeps modified history");
        end
        for (int k = 0; k < DEPTH + 1; k++)
            do_hint(1'b0, 1'b1, "R9,R11 pop restores newest");
        do_hint(1'b0, 1'b1, "R10 pop after drain");

        // R12 both hints together, hints while busy, hints with a request
        do_branch(16'h0022, 1'b0, 1'b0, 1'b0);
        do_hint(1'b1, 1'b1, "R12 entry wins over exit");
        do_branch(16'h0023, 1'b1, 1'b1, 1'b0);
        do_branch(16'h0024, 1'b1, 1'b0, 1'b1);
        do_hint(1'b0, 1'b1, "R12 single pushed entry restored");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) do_hint(1'b1, 1'b0, "R9 random push");
            else if (r == 1) do_hint(1'b0, 1'b1, "R9,R10 random pop");
            else begin
                logic [PC_W-1:0] pc = pcs[$urandom_range(0, 5)];
                bit t = ($urandom_range(0, 7) == 0) ? bit'($urandom_range(0, 1))
                                                   : (m_mod[1] ^ pc[0] ^ m_plain[3]);
                do_branch(pc, t, bit'($urandom_range(0, 9) == 0),
                          bit'($urandom_range(0, 9) == 0));
            end
        end

        done = 1'b1;
        report();
    end
endmodule